// File: doc/BRIEF.md
# Receive Frame Descriptor Updater

This engine places received frames into frame descriptors that live in shared memory. A descriptor is a small block of 32-bit words. It holds a control/status word, a link to the next descriptor, a size word, and the frame payload, which starts sixteen bytes into the descriptor. The engine keeps a base address and an offset, and their sum selects the current descriptor. Software sets up the chain and steers the engine with three opcodes: load base, start and resume.

A frame arrives in two steps. First its byte length is handed over on its own handshake, then its payload follows as a stream of 32-bit words. While the engine is ready, it reads the descriptor header, writes the payload words, marks the descriptor complete and records the size. It then pulses a frame-received event and counts the frame. Last, it decides from the descriptor's control bits whether to follow the link, suspend or stop for lack of resources. In any state other than ready, the engine still consumes the frame so that the stream stays in step, but it does not touch memory. Only the simplified layout, with the payload inside the descriptor, is handled.

Top module: `rfd_updater`

## Requirements
- R1: After reset the engine state is idle (code 0), the good-frame count is 0, both event outputs are low and no memory request is made.
- R2: Opcode 6 (load base) copies `cmd_ptr` into the base. Opcode 1 (start) copies `cmd_ptr` into the offset and sets the state to ready (code 4). Any opcode other than 1, 2 and 6 changes nothing.
- R3: In the ready state, a frame of L bytes is written as ceil(L/4) words. Word k goes to byte address base+offset+0x10+4k, and no word is written beyond that range.
- R4: After the payload, the status word at descriptor offset 0 is written back with bit 15 (complete) and bit 13 (ok) set and all other bits kept.
- R5: The size word at descriptor offset 0xC keeps its upper 16 bits. Its lower 16 bits become bit 15 (end of frame) set, with L+4 in bits 13:0.
- R6: Each stored frame gives one single-cycle pulse on `ev_frame`, and `good_frames` rises by one in the same cycle.
- R7: If bit 31 (end of list) of the descriptor's status word is set, the state becomes no-resources (code 2) and `ev_not_ready` pulses. This check takes precedence over bit 30.
- R8: Otherwise, if bit 30 (suspend) is set, the state becomes suspended (code 1) and `ev_not_ready` pulses.
- R9: Otherwise the offset takes the link word read from descriptor offset 4, and the state stays ready.
- R10: A frame that arrives outside the ready state is consumed word by word. It causes no memory access, no event and no count change.
- R11: Opcode 2 (resume) acts only in the ready state. It reads the current descriptor, and if bit 30 is clear it moves the offset to that descriptor's link word. Otherwise nothing changes.
- R12: Every memory address is word aligned. An access is held with an unchanged address, data and direction until `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode present |
| cmd_op | input | 3 | Opcode: 1 start, 2 resume, 6 load base |
| cmd_ptr | input | 32 | Pointer operand for start and load base |
| cmd_ready | output | 1 | Engine can take an opcode |
| frm_len_valid | input | 1 | Frame length present |
| frm_len | input | 14 | Frame length in bytes |
| frm_len_ready | output | 1 | Engine takes the length |
| frm_data_valid | input | 1 | Payload word present |
| frm_data | input | 32 | Payload word |
| frm_data_ready | output | 1 | Payload word taken |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| ev_frame | output | 1 | Frame-received pulse |
| ev_not_ready | output | 1 | Engine left ready pulse |
| ru_state | output | 3 | Engine state code |
| good_frames | output | 16 | Count of stored frames |

## Verification
The embedded properties watch, on every cycle, that memory stays quiet while the engine waits or discards a frame, that addresses are aligned, that a stalled access holds still, that the state code is always legal, and that every frame pulse goes with one counter step and every not-ready pulse with a suspended or no-resources state. Only the directed scenarios can show that payload words, status and size values land at the right addresses. The same holds for following the link, the precedence of end-of-list over suspend, and the two cases where resume must not move the offset; these are observed in the bench's memory model and through where the next frame lands.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

  typedef enum logic [2:0] {
    RU_IDLE  = 3'd0,
    RU_SUSP  = 3'd1,
    RU_NORES = 3'd2,
    RU_READY = 3'd4
  } ru_state_e;

  localparam logic [2:0] OP_START  = 3'd1;
  localparam logic [2:0] OP_RESUME = 3'd2;
  localparam logic [2:0] OP_LDBASE = 3'd6;

  localparam int BIT_EL   = 31;
  localparam int BIT_SUSP = 30;
  localparam int BIT_DONE = 15;
  localparam int BIT_OK   = 13;

  localparam logic [31:0] OFS_LINK = 32'h4;
  localparam logic [31:0] OFS_SIZE = 32'hC;
  localparam logic [31:0] OFS_DATA = 32'h10;

  typedef enum logic [3:0] {
    F_IDLE,
    F_RD_STAT,
    F_RD_LINK,
    F_RD_SIZE,
    F_DATA,
    F_WR_STAT,
    F_WR_SIZE,
    F_DROP,
    F_RS_STAT,
    F_RS_LINK
  } fsm_e;

endpackage

// File: rtl/rfd_len_calc.sv
module rfd_len_calc #(
  parameter int LEN_W = 14
) (
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] nwords,
  output logic [15:0]      size_lo
);
  localparam int SZ_W = (LEN_W < 14) ? LEN_W : 14;

  logic [LEN_W:0] rounded;
  logic [LEN_W:0] with_crc;

  always_comb begin
    rounded  = {1'b0, len} + (LEN_W+1)'(3);
    nwords   = rounded[LEN_W:2];
    with_crc = {1'b0, len} + (LEN_W+1)'(4);
    size_lo  = 16'h8000;
    size_lo[SZ_W-1:0] = with_crc[SZ_W-1:0];
  end
endmodule

// File: rtl/rfd_ctx.sv
module rfd_ctx
  import rfd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_base,
  input  logic          ld_off,
  input  logic [AW-1:0] ptr_in,
  input  logic          ld_state,
  input  ru_state_e     state_in,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] off_q,
  output ru_state_e     state_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      off_q   <= '0;
      state_q <= RU_IDLE;
    end else begin
      if (ld_base)  base_q  <= ptr_in;
      if (ld_off)   off_q   <= ptr_in;
      if (ld_state) state_q <= state_in;
    end
  end

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RU_IDLE) || (state_q == RU_SUSP) ||
    (state_q == RU_NORES) || (state_q == RU_READY));

endmodule

// File: rtl/rfd_counter.sv
module rfd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count_d;
  end
endmodule

// File: rtl/rfd_seq.sv
module rfd_seq
  import rfd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  output logic             cmd_ready,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] len_in,
  output logic             len_ready,
  input  logic             data_valid,
  input  logic [31:0]      data_in,
  output logic             data_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  input  logic [AW-1:0]    base_q,
  input  logic [AW-1:0]    off_q,
  input  ru_state_e        state_q,
  output logic             ld_base,
  output logic             ld_off,
  output logic             off_from_mem,
  output logic             ld_state,
  output ru_state_e        state_in,
  output logic             frame_done,
  output logic             ev_frame,
  output logic             ev_not_ready
);

  fsm_e             fsm_q, fsm_d;
  logic [AW-1:0]    desc_q, desc_d;
  logic [31:0]      stat_q, stat_d;
  logic [31:0]      link_q, link_d;
  logic [15:0]      szhi_q, szhi_d;
  logic [LEN_W-1:0] nw_q, nw_d;
  logic [15:0]      szlo_q, szlo_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic             evf_d, evn_d;
  logic             evf_q, evn_q;

  logic [LEN_W-1:0] calc_nw;
  logic [15:0]      calc_szlo;
  logic             last_word;

  rfd_len_calc #(.LEN_W(LEN_W)) u_len (
    .len     (len_in),
    .nwords  (calc_nw),
    .size_lo (calc_szlo)
  );

  assign last_word = (idx_q == nw_q - LEN_W'(1));
  assign cmd_ready = (fsm_q == F_IDLE);
  assign len_ready = (fsm_q == F_IDLE) && !cmd_valid;

  always_comb begin
    fsm_d        = fsm_q;
    desc_d       = desc_q;
    stat_d       = stat_q;
    link_d       = link_q;
    szhi_d       = szhi_q;
    nw_d         = nw_q;
    szlo_d       = szlo_q;
    idx_d        = idx_q;
    evf_d        = 1'b0;
    evn_d        = 1'b0;
    ld_base      = 1'b0;
    ld_off       = 1'b0;
    off_from_mem = 1'b0;
    ld_state     = 1'b0;
    state_in     = state_q;
    frame_done   = 1'b0;
    data_ready   = 1'b0;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = desc_q;
    mem_wdata    = '0;

    unique case (fsm_q)
      F_IDLE: begin
        if (cmd_valid) begin
          unique case (cmd_op)
            OP_LDBASE: ld_base = 1'b1;
            OP_START: begin
              ld_off   = 1'b1;
              ld_state = 1'b1;
              state_in = RU_READY;
            end
            OP_RESUME: begin
              if (state_q == RU_READY) begin
                desc_d = base_q + off_q;
                fsm_d  = F_RS_STAT;
              end
            end
            default: ;
          endcase
        end else if (len_valid) begin
          desc_d = base_q + off_q;
          nw_d   = calc_nw;
          szlo_d = calc_szlo;
          idx_d  = '0;
          if (state_q == RU_READY)   fsm_d = F_RD_STAT;
          else if (calc_nw != '0)    fsm_d = F_DROP;
        end
      end
      F_RD_STAT: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          stat_d = mem_rdata;
          fsm_d  = F_RD_LINK;
        end
      end
      F_RD_LINK: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + OFS_LINK;
        if (mem_gnt) begin
          link_d = mem_rdata;
          fsm_d  = F_RD_SIZE;
        end
      end
      F_RD_SIZE: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + OFS_SIZE;
        if (mem_gnt) begin
          szhi_d = mem_rdata[31:16];
          fsm_d  = (nw_q == '0) ? F_WR_STAT : F_DATA;
        end
      end
      F_DATA: begin
        mem_req    = data_valid;
        mem_we     = 1'b1;
        mem_addr   = desc_q + OFS_DATA + {{(AW-LEN_W-2){1'b0}}, idx_q, 2'b00};
        mem_wdata  = data_in;
        data_ready = mem_gnt;
        if (data_valid && mem_gnt) begin
          idx_d = idx_q + LEN_W'(1);
          if (last_word) fsm_d = F_WR_STAT;
        end
      end
      F_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = stat_q;
        mem_wdata[BIT_DONE] = 1'b1;
        mem_wdata[BIT_OK]   = 1'b1;
        if (mem_gnt) fsm_d = F_WR_SIZE;
      end
      F_WR_SIZE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + OFS_SIZE;
        mem_wdata = {szhi_q, szlo_q};
        if (mem_gnt) begin
          fsm_d      = F_IDLE;
          frame_done = 1'b1;
          evf_d      = 1'b1;
          if (stat_q[BIT_EL]) begin
            ld_state = 1'b1;
            state_in = RU_NORES;
            evn_d    = 1'b1;
          end else if (stat_q[BIT_SUSP]) begin
            ld_state = 1'b1;
            state_in = RU_SUSP;
            evn_d    = 1'b1;
          end else begin
            ld_off = 1'b1;
          end
        end
      end
      F_DROP: begin
        data_ready = 1'b1;
        if (data_valid) begin
          idx_d = idx_q + LEN_W'(1);
          if (last_word) fsm_d = F_IDLE;
        end
      end
      F_RS_STAT: begin
        mem_req = 1'b1;
        if (mem_gnt) fsm_d = mem_rdata[BIT_SUSP] ? F_IDLE : F_RS_LINK;
      end
      F_RS_LINK: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + OFS_LINK;
        if (mem_gnt) begin
          ld_off       = 1'b1;
          off_from_mem = 1'b1;
          fsm_d        = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      desc_q <= '0;
      stat_q <= '0;
      link_q <= '0;
      szhi_q <= '0;
      nw_q   <= '0;
      szlo_q <= '0;
      idx_q  <= '0;
      evf_q  <= 1'b0;
      evn_q  <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      desc_q <= desc_d;
      stat_q <= stat_d;
      link_q <= link_d;
      szhi_q <= szhi_d;
      nw_q   <= nw_d;
      szlo_q <= szlo_d;
      idx_q  <= idx_d;
      evf_q  <= evf_d;
      evn_q  <= evn_d;
    end
  end

  assign ev_frame     = evf_q;
  assign ev_not_ready = evn_q;

  assert_idle_no_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_IDLE) |-> !mem_req);

  assert_drop_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_DROP) |-> (!mem_req && !ev_frame));

  assert_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && (fsm_q != F_DATA)) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/rfd_updater.sv
module rfd_updater
  import rfd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_ptr,
  output logic             cmd_ready,
  input  logic             frm_len_valid,
  input  logic [LEN_W-1:0] frm_len,
  output logic             frm_len_ready,
  input  logic             frm_data_valid,
  input  logic [31:0]      frm_data,
  output logic             frm_data_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  output logic             ev_frame,
  output logic             ev_not_ready,
  output logic [2:0]       ru_state,
  output logic [CNT_W-1:0] good_frames
);

  logic [AW-1:0] base_q, off_q, ptr_mux;
  ru_state_e     state_q, state_in;
  logic          ld_base, ld_off, off_from_mem, ld_state, frame_done;
  logic [AW-1:0] link_word;

  assign link_word = mem_rdata[AW-1:0];

  always_comb begin
    if (off_from_mem)   ptr_mux = link_word;
    else if (frame_done) ptr_mux = u_seq.link_q[AW-1:0];
    else                ptr_mux = cmd_ptr;
  end

  rfd_ctx #(.AW(AW)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_base  (ld_base),
    .ld_off   (ld_off),
    .ptr_in   (ptr_mux),
    .ld_state (ld_state),
    .state_in (state_in),
    .base_q   (base_q),
    .off_q    (off_q),
    .state_q  (state_q)
  );

  rfd_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_ready    (cmd_ready),
    .len_valid    (frm_len_valid),
    .len_in       (frm_len),
    .len_ready    (frm_len_ready),
    .data_valid   (frm_data_valid),
    .data_in      (frm_data),
    .data_ready   (frm_data_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_gnt      (mem_gnt),
    .mem_rdata    (mem_rdata),
    .base_q       (base_q),
    .off_q        (off_q),
    .state_q      (state_q),
    .ld_base      (ld_base),
    .ld_off       (ld_off),
    .off_from_mem (off_from_mem),
    .ld_state     (ld_state),
    .state_in     (state_in),
    .frame_done   (frame_done),
    .ev_frame     (ev_frame),
    .ev_not_ready (ev_not_ready)
  );

  rfd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_done),
    .count (good_frames)
  );

  assign ru_state = state_q;

  assert_frame_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |-> (good_frames == $past(good_frames) + CNT_W'(1)));

  assert_notready_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_not_ready |-> (ev_frame && ((ru_state == 3'd1) || (ru_state == 3'd2))));

  assert_count_only_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_frame |-> $stable(good_frames));

endmodule

// File: tb/rfd_updater_bench.sv
module rfd_updater_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_ptr;
  logic        cmd_ready;
  logic        frm_len_valid;
  logic [13:0] frm_len;
  logic        frm_len_ready;
  logic        frm_data_valid;
  logic [31:0] frm_data;
  logic        frm_data_ready;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        ev_frame, ev_not_ready;
  logic [2:0]  ru_state;
  logic [15:0] good_frames;

  int tests = 0;
  int fails = 0;
  int n_evf = 0;
  int n_evn = 0;
  int n_req = 0;

  logic [31:0] mem [0:255];
  logic        stall_on = 1'b0;
  logic [7:0]  lfsr = 8'h5A;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfd_updater u_rfd_updater (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ptr(cmd_ptr), .cmd_ready(cmd_ready),
    .frm_len_valid(frm_len_valid), .frm_len(frm_len), .frm_len_ready(frm_len_ready),
    .frm_data_valid(frm_data_valid), .frm_data(frm_data), .frm_data_ready(frm_data_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .ev_frame(ev_frame), .ev_not_ready(ev_not_ready),
    .ru_state(ru_state), .good_frames(good_frames)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_gnt   = !stall_on || lfsr[0];

  always @(posedge clk)
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (ev_frame)     n_evf <= n_evf + 1;
    if (ev_not_ready) n_evn <= n_evn + 1;
    if (mem_req)      n_req <= n_req + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] v);
    mem[a[9:2]] = v;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [31:0] p);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ptr = p;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  function automatic logic [31:0] pat(input int seed, input int k);
    return 32'hA500_0000 + (seed << 8) + k;
  endfunction

  task automatic send_frame(input int len, input int seed);
    int nw;
    nw = (len + 3) / 4;
    @(negedge clk);
    frm_len_valid = 1'b1; frm_len = 14'(len);
    #1;
    while (!frm_len_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    frm_len_valid = 1'b0;
    for (int k = 0; k < nw; k++) begin
      frm_data_valid = 1'b1; frm_data = pat(seed, k);
      #1;
      while (!frm_data_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
    end
    frm_data_valid = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 state", 32'(ru_state), 32'd0);
    chk("R1 count", 32'(good_frames), 32'd0);
    chk("R1 events", {30'd0, ev_frame, ev_not_ready}, 32'd0);
    chk("R1 no req", 32'(n_req), 32'd0);
  endtask

  task automatic t_basic_store();
    int f0, n0;
    wr(32'h100, 32'h0000_0001); wr(32'h104, 32'h40);
    wr(32'h10C, 32'hABCD_1234); wr(32'h11C, 32'hDEAD_BEEF);
    send_cmd(3'd6, 32'h100);
    send_cmd(3'd1, 32'h000);
    chk("R2 start ready", 32'(ru_state), 32'd4);
    f0 = n_evf; n0 = n_evn;
    send_frame(10, 1);
    for (int k = 0; k < 3; k++) chk("R3 payload", rd(32'h110 + 4*k), pat(1, k));
    chk("R3 no overrun", rd(32'h11C), 32'hDEAD_BEEF);
    chk("R4 status", rd(32'h100), 32'h0000_A001);
    chk("R5 size", rd(32'h10C), 32'hABCD_800E);
    chk("R6 pulse", 32'(n_evf - f0), 32'd1);
    chk("R6 count", 32'(good_frames), 32'd1);
    chk("R9 stays ready", 32'(ru_state), 32'd4);
    chk("R9 no notready", 32'(n_evn - n0), 32'd0);
  endtask

  task automatic t_link_suspend();
    int n0;
    wr(32'h140, 32'h4000_0000); wr(32'h144, 32'h80); wr(32'h14C, 32'h0);
    wr(32'h158, 32'h1111_1111);
    stall_on = 1'b1;
    n0 = n_evn;
    send_frame(8, 2);
    stall_on = 1'b0;
    chk("R9 link followed w0", rd(32'h150), pat(2, 0));
    chk("R3 whole words w1", rd(32'h154), pat(2, 1));
    chk("R3 no overrun", rd(32'h158), 32'h1111_1111);
    chk("R12 stalled size", rd(32'h14C), 32'h0000_800C);
    chk("R8 status", rd(32'h140), 32'h4000_A000);
    chk("R8 suspended", 32'(ru_state), 32'd1);
    chk("R8 notready pulse", 32'(n_evn - n0), 32'd1);
    chk("R6 count", 32'(good_frames), 32'd2);
  endtask

  task automatic t_drop();
    int r0, f0;
    r0 = n_req; f0 = n_evf;
    send_frame(6, 3);
    chk("R10 no mem", 32'(n_req - r0), 32'd0);
    chk("R10 no event", 32'(n_evf - f0), 32'd0);
    chk("R10 count held", 32'(good_frames), 32'd2);
    chk("R10 desc untouched", rd(32'h150), pat(2, 0));
  endtask

  task automatic t_resume_not_ready();
    int r0;
    r0 = n_req;
    send_cmd(3'd2, 32'h0);
    chk("R11 no act when susp", 32'(ru_state), 32'd1);
    chk("R11 no mem when susp", 32'(n_req - r0), 32'd0);
  endtask

  task automatic t_end_of_list();
    int n0;
    wr(32'h180, 32'hC000_0000); wr(32'h184, 32'h0); wr(32'h18C, 32'h7777_0000);
    wr(32'h194, 32'h2222_2222);
    send_cmd(3'd1, 32'h080);
    n0 = n_evn;
    send_frame(1, 4);
    chk("R3 single word", rd(32'h190), pat(4, 0));
    chk("R3 no overrun", rd(32'h194), 32'h2222_2222);
    chk("R5 size len1", rd(32'h18C), 32'h7777_8005);
    chk("R7 status", rd(32'h180), 32'hC000_A000);
    chk("R7 nores wins", 32'(ru_state), 32'd2);
    chk("R7 notready pulse", 32'(n_evn - n0), 32'd1);
  endtask

  task automatic t_ignored_ops();
    send_cmd(3'd3, 32'h300);
    chk("R2 op3 ignored", 32'(ru_state), 32'd2);
    send_cmd(3'd0, 32'h300);
    chk("R2 op0 ignored", 32'(ru_state), 32'd2);
  endtask

  task automatic t_resume_ready();
    wr(32'h1C0, 32'h4000_0000); wr(32'h1C4, 32'h20);
    wr(32'h120, 32'h8000_0000); wr(32'h124, 32'h60); wr(32'h12C, 32'h0);
    wr(32'h160, 32'h8000_0000); wr(32'h164, 32'h0);
    wr(32'h130, 32'h0); wr(32'h170, 32'h0);
    send_cmd(3'd1, 32'h0C0);
    send_cmd(3'd2, 32'h0);
    chk("R11 held by suspend bit", 32'(ru_state), 32'd4);
    wr(32'h1C0, 32'h0000_0000);
    send_cmd(3'd2, 32'h0);
    send_frame(4, 5);
    chk("R11 advanced once", rd(32'h130), pat(5, 0));
    chk("R11 not twice", rd(32'h170), 32'h0);
    chk("R5 size len4", rd(32'h12C), 32'h0000_8008);
    chk("R6 count", 32'(good_frames), 32'd4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_ptr = '0;
    frm_len_valid = 1'b0; frm_len = '0;
    frm_data_valid = 1'b0; frm_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_store();
    t_link_suspend();
    t_drop();
    t_resume_not_ready();
    t_end_of_list();
    t_ignored_ops();
    t_resume_ready();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule